// File: doc/BRIEF.md
# Clock Stop Sequencer

This block moves a group of clock outputs into and out of a low-power state. An asynchronous, active-low power-down request is first brought into the reference-clock domain by a synchronizer. When power-down is requested, each gated output finishes its current high phase and is then parked low. Each gate updates only on the falling edge of its own source clock, so a slow output can take several reference cycles to reach low. The controller waits until every gate has confirmed it is closed. Only then does it drop the oscillator and VCO enables.

On exit, the oscillator and VCO enables are turned on again. The outputs stay low for a fixed settle count, and then they are released on their next falling edge. The first pulse of every output therefore has full width. Each output also has its own enable bit. An output whose bit is 0 stays low, and a change to a bit takes effect only while that output's source clock is low. If power-down is requested again during the settle interval, the controller goes straight back into the stopping sequence.

Top module: `clkstop_seq`

## Requirements
- R1: While reset is asserted, every gated output, `vco_en` and `xtal_en` are low.
- R2: `pd_n` passes through a two-stage synchronizer. When `pd_n` rises while the block is powered down, `vco_en` and `xtal_en` go high at the third rising edge of `clk_ref` after the change. Before that edge they stay low.
- R3: When `pd_n` falls while the block is running, output 0 (whose source is `clk_ref`) still produces its high phases starting at the first, second and third rising edges of `clk_ref` after the change. From the fourth rising edge on, it stays low.
- R4: `vco_en` and `xtal_en` are always equal. Whenever they are low, every gated output is low. After a power-down request from the running state, they fall within 20 reference cycles.
- R5: The enables are dropped only after the slowest output has made its final falling edge.
- R6: In the running state, an output whose `out_en` bit is 0 never rises. An output whose bit is 1 produces one rising edge per period of its source clock.
- R7: Every high pulse on a gated output lasts exactly one high phase of its source clock, including while `out_en` bits change at arbitrary times.
- R8: After `pd_n` rises while the block is powered down, output 0 stays low through the 19th rising edge of `clk_ref`. Its first high phase starts at the 20th rising edge, which is SYNC_STAGES + 1 + SETTLE_CYC + 1 edges with the default parameters.
- R9: If `pd_n` falls during the settle interval, no output ever rises. The enables stay high through the fifth rising edge after the change and are low after the sixth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that runs the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| src_clk | input | N_OUT | Free-running clocks to be gated; bit 0 is expected to be the reference |
| out_en | input | N_OUT | Per-output enable, 1 = switching, 0 = held low |
| clk_out | output | N_OUT | Gated clock outputs |
| vco_en | output | 1 | VCO enable |
| xtal_en | output | 1 | Crystal oscillator enable |

## Verification
Two things can happen in the same cycle. One is an enable bit changing on an output. The other is the sequencer's own request, which drops on power-down entry or rises on wake. Both are sampled by the same falling-edge gate register. The bench toggles enable bits at times that are not aligned to any clock edge while outputs run, stop and restart. It measures the width of every high pulse against the half period of that output's source, so a clipped pulse caused by either source is caught. The abort case, where a power-down request lands in the middle of the settle count, is checked against the exact edge numbers stated in R9.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    typedef enum logic [1:0] {
        PS_RUN      = 2'd0,
        PS_STOPPING = 2'd1,
        PS_OFF      = 2'd2,
        PS_WAKING   = 2'd3
    } pstate_e;

    function automatic int cnt_width(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/cs_sync.sv
`timescale 1ns/1ps
module cs_sync #(
    parameter int W         = 1,
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= {W{RESET_VAL}};
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cs_gate_cell.sv
`timescale 1ns/1ps
module cs_gate_cell (
    input  logic src,
    input  logic rst_n,
    input  logic want,
    output logic gated,
    output logic held_on
);
    logic en_d, en_q;

    always_comb begin
        en_d = want;
    end

    // Sampled on the falling edge: the gate only moves while src is low.
    always_ff @(negedge src or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign gated   = src & en_q;
    assign held_on = en_q;
endmodule

// File: rtl/cs_fsm.sv
`timescale 1ns/1ps
module cs_fsm
    import clkstop_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    parameter int DWELL_CYC  = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pd_req,
    input  logic    all_low,
    output logic    clk_req,
    output logic    osc_en,
    output pstate_e state
);
    localparam int MAXC = (SETTLE_CYC > DWELL_CYC) ? SETTLE_CYC : DWELL_CYC;
    localparam int CW   = cnt_width(MAXC);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] DWELL_LAST  = CW'(DWELL_CYC - 1);

    typedef struct packed {
        pstate_e       state;
        logic [CW-1:0] cnt;
        logic          req;
        logic          osc;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            PS_RUN: begin
                r_d.req = 1'b1;
                r_d.osc = 1'b1;
                if (pd_req) begin
                    r_d.state = PS_STOPPING;
                    r_d.cnt   = '0;
                    r_d.req   = 1'b0;
                end
            end
            PS_STOPPING: begin
                r_d.req = 1'b0;
                r_d.osc = 1'b1;
                if (r_q.cnt == DWELL_LAST) begin
                    if (all_low) begin
                        r_d.state = PS_OFF;
                        r_d.osc   = 1'b0;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            PS_OFF: begin
                r_d.req = 1'b0;
                r_d.osc = 1'b0;
                if (!pd_req) begin
                    r_d.state = PS_WAKING;
                    r_d.cnt   = '0;
                    r_d.osc   = 1'b1;
                end
            end
            PS_WAKING: begin
                r_d.req = 1'b0;
                r_d.osc = 1'b1;
                if (pd_req) begin
                    r_d.state = PS_STOPPING;
                    r_d.cnt   = '0;
                end else if (r_q.cnt == SETTLE_LAST) begin
                    r_d.state = PS_RUN;
                    r_d.req   = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: begin
                r_d.state = PS_OFF;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: PS_OFF, cnt: '0, req: 1'b0, osc: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_req = r_q.req;
    assign osc_en  = r_q.osc;
    assign state   = r_q.state;
endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 16
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic [N_OUT-1:0] src_clk,
    input  logic [N_OUT-1:0] out_en,
    output logic [N_OUT-1:0] clk_out,
    output logic             vco_en,
    output logic             xtal_en
);
    // Minimum stop dwell covers the acknowledge synchronizer latency.
    localparam int DWELL_CYC = SYNC_STAGES + 1;

    logic             pd_n_sync;
    logic             pd_req;
    logic             clk_req;
    logic             osc_en;
    logic             all_low;
    pstate_e          fsm_state;
    logic [N_OUT-1:0] want;
    logic [N_OUT-1:0] held_on;
    logic [N_OUT-1:0] held_sync;

    cs_sync #(.W(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_pd_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (pd_n),
        .q     (pd_n_sync)
    );

    assign pd_req = ~pd_n_sync;

    cs_sync #(.W(N_OUT), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ack_sync (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .d     (held_on),
        .q     (held_sync)
    );

    assign all_low = ~|held_sync;

    cs_fsm #(.SETTLE_CYC(SETTLE_CYC), .DWELL_CYC(DWELL_CYC)) u_fsm (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .pd_req  (pd_req),
        .all_low (all_low),
        .clk_req (clk_req),
        .osc_en  (osc_en),
        .state   (fsm_state)
    );

    assign want = {N_OUT{clk_req}} & out_en;

    for (genvar g = 0; g < N_OUT; g++) begin : g_gate
        cs_gate_cell u_cell (
            .src     (src_clk[g]),
            .rst_n   (rst_n),
            .want    (want[g]),
            .gated   (clk_out[g]),
            .held_on (held_on[g])
        );
    end

    assign vco_en  = osc_en;
    assign xtal_en = osc_en;
endmodule

// File: rtl/clkstop_seq_chk.sv
`timescale 1ns/1ps
module clkstop_seq_chk
    import clkstop_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input pstate_e          state,
    input logic             pd_req,
    input logic             all_low,
    input logic             vco_en,
    input logic [N_OUT-1:0] clk_out
);
    AST_OFF_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !vco_en |-> (clk_out == '0)); // R4

    AST_OSC_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> $past(all_low)); // R5

    AST_OSC_RISE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |-> $past(!pd_req)); // R2

    AST_SETTLE_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAKING) |-> (clk_out == '0)); // R8

    AST_RUN_ONLY_FROM_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && $past(state) != PS_RUN) |-> ($past(state) == PS_WAKING)); // R8

    AST_WAKE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAKING && pd_req) |=> (state == PS_STOPPING)); // R9
endmodule

bind clkstop_seq clkstop_seq_chk #(.N_OUT(N_OUT)) u_chk (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .state   (fsm_state),
    .pd_req  (pd_req),
    .all_low (all_low),
    .vco_en  (vco_en),
    .clk_out (clk_out)
);

// File: tb/sim_clkstop_seq.sv
`timescale 1ns/1ps
module sim_clkstop_seq;
    localparam int N = 4;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic         pd_n  = 1'b0;
    logic         s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [N-1:0] en;
    logic [N-1:0] src;
    logic [N-1:0] clk_out;
    logic         vco_en, xtal_en;

    always #10 clk = ~clk;   // 50 MHz reference
    always #20 s1 = ~s1;
    always #40 s2 = ~s2;
    always #80 s3 = ~s3;     // slowest output, 8 reference cycles
    assign src = {s3, s2, s1, clk};

    clkstop_seq #(.N_OUT(N), .SYNC_STAGES(2), .SETTLE_CYC(16)) u0 (
        .clk_ref (clk), .rst_n (rst_n), .pd_n (pd_n), .src_clk (src),
        .out_en (en), .clk_out (clk_out), .vco_en (vco_en), .xtal_en (xtal_en)
    );

    int  n_chk = 0, n_fail = 0;
    bit  counting = 1'b0;
    int  rises [N];
    time last_fall [N];
    time t_vco_off = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic clear_rises();
        for (int i = 0; i < N; i++) rises[i] = 0;
    endtask

    // R7 pulse width and edge bookkeeping per output
    for (genvar g = 0; g < N; g++) begin : g_mon
        time t_rise = 0;
        always @(posedge clk_out[g]) begin
            t_rise = $time;
            if (counting) rises[g]++;
        end
        always @(negedge clk_out[g]) begin
            last_fall[g] = $time;
            if (rst_n && t_rise != 0)
                chk(($time - t_rise) == 10 * (1 << g), "R7", $time - t_rise, 10 * (1 << g));
        end
    end

    always @(negedge vco_en) t_vco_off = $time;

    // R4 enables in step, outputs quiet while oscillator off
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            chk(vco_en == xtal_en, "R4", xtal_en, vco_en);
            if (!vco_en) chk(clk_out == '0, "R4", clk_out, 0);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int wait_cyc;
        en = '1;
        clear_rises();
        for (int i = 0; i < N; i++) last_fall[i] = 0;
        repeat (3) tick();
        chk(clk_out == '0, "R1", clk_out, 0);
        chk(vco_en == 1'b0, "R1", vco_en, 0);
        chk(xtal_en == 1'b0, "R1", xtal_en, 0);

        @(negedge clk) rst_n = 1'b1;
        repeat (5) tick();
        chk(vco_en == 1'b0, "R2", vco_en, 0);

        // Wake from reset: exact sync latency and settle hold
        @(negedge clk) pd_n = 1'b1;
        for (int k = 1; k <= 22; k++) begin
            tick();
            chk(vco_en == (k >= 3), "R2", vco_en, k >= 3);
            chk(clk_out[0] == (k >= 20), "R8", clk_out[0], k >= 20);
        end

        // R6 sweep over every enable pattern
        for (int p = 0; p < (1 << N); p++) begin
            @(negedge clk) en = N'(p);
            repeat (24) tick();
            clear_rises();
            counting = 1'b1;
            repeat (32) tick();
            counting = 1'b0;
            for (int i = 0; i < N; i++) begin
                int exp_r;
                exp_r = p[i] ? (32 >> i) : 0;
                chk(rises[i] == exp_r, "R6", rises[i], exp_r);
            end
        end

        // R7 unaligned enable toggling
        for (int j = 0; j < 40; j++) begin
            #(37 + (j * 13) % 50);
            en = en ^ N'(1 << (j % N));
        end
        en = '1;
        repeat (24) tick();

        // R3 entry: output 0 stops after the third edge
        @(negedge clk) pd_n = 1'b0;
        for (int k = 1; k <= 6; k++) begin
            tick();
            chk(clk_out[0] == (k <= 3), "R3", clk_out[0], k <= 3);
        end
        wait_cyc = 6;
        while (vco_en && wait_cyc < 40) begin
            tick();
            wait_cyc++;
        end
        chk(wait_cyc <= 20, "R4", wait_cyc, 20);
        chk(last_fall[3] < t_vco_off, "R5", last_fall[3], t_vco_off);
        clear_rises();
        counting = 1'b1;
        repeat (20) tick();
        counting = 1'b0;
        for (int i = 0; i < N; i++) chk(rises[i] == 0, "R4", rises[i], 0);

        // R9 abort during settle
        @(negedge clk) pd_n = 1'b1;
        repeat (8) tick();
        chk(vco_en == 1'b1, "R9", vco_en, 1);
        clear_rises();
        counting = 1'b1;
        @(negedge clk) pd_n = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            tick();
            chk(vco_en == (k <= 5), "R9", vco_en, k <= 5);
        end
        counting = 1'b0;
        for (int i = 0; i < N; i++) chk(rises[i] == 0, "R9", rises[i], 0);

        // Recovery after abort
        @(negedge clk) pd_n = 1'b1;
        for (int k = 1; k <= 22; k++) begin
            tick();
            chk(clk_out[0] == (k >= 20), "R8", clk_out[0], k >= 20);
        end

        summary();
        $finish;
    end
endmodule